// File: doc/BRIEF.md
# Coded-Ratio Reference Divider and Phase-Frequency Detector

This block is the digital core of a loop that locks an external oscillator to a video reference. One of two reference clocks is picked by a select input. Its rising edges are counted down by a pre-divide value P. The rising edges of the oscillator's feedback clock are counted down by a feedback value M. Both values come from one fixed 16-entry table, indexed by a 4-bit ratio code. Codes that share an M value share the same loop response, so one filter setting covers a whole group of rate conversions.

Each divider issues a one-cycle strobe at the end of every count. A phase-frequency detector turns the two strobe streams into up and down requests for an external charge pump. All logic runs on one fast sampling clock `clk`. The reference and feedback clocks are sampled as levels, and each level must hold for at least one `clk` cycle.

Top module: `ratio_pll_core`

## Requirements
- R1: `refSel` = 1 makes the reference divider count rising edges of `refClk1`. `refSel` = 0 makes it count rising edges of `refClk0`. The unselected clock has no effect on `refStrobe`.
- R2: A rising edge is a sample of 1 that follows a sample of 0. `refStrobe` goes high for one cycle, in the cycle after the clock edge that samples the P-th counted reference edge. The interval between successive `refStrobe` pulses is therefore P reference periods.
- R3: `fbStrobe` behaves the same way for rising edges of `fbClk`, with the value M. Its interval is M feedback periods.
- R4: The ratio code selects the (P, M) pair as follows.
  - 0000: 1000/1000
  - 0001: 1001/1000
  - 0010: 11000/4004
  - 0011: 11011/4000
  - 0100: 11000/4000
  - 0101: 4004/4004
  - 0110: 4004/4000
  - 0111: 1000/1001
  - 1000: 250/91
  - 1001: 253/92
  - 1010: 92/92
  - 1011 to 1111: P = 1, with M = 600, 800, 1728, 1716 and 960 in that code order.
- R5: A change of `ratioCode` does not shorten or stretch a count already in progress. Each divider finishes its current count with the old value and takes the new value when it wraps.
- R6: While `rst` is high (sampled on `clk`), both counts return to zero, the limits load from the present code, and `up`, `down`, `refStrobe` and `fbStrobe` are 0. After release, the first strobes come after full P and M counts.
- R7: The cycle after `refStrobe`, `up` is 1 unless a feedback strobe is also pending. The cycle after `fbStrobe`, `down` is 1 unless a reference strobe is also pending. When both requests would be set, both clear to 0 in that cycle.
- R8: `up` and `down` are never 1 in the same cycle.
- R9: A strobe never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| rst | input | 1 | Active-high master reset, synchronous to clk |
| refClk0 | input | 1 | Reference clock choice 0 |
| refClk1 | input | 1 | Reference clock choice 1 |
| fbClk | input | 1 | Feedback clock from the external oscillator |
| refSel | input | 1 | Reference select, 1 picks refClk1 |
| ratioCode | input | 4 | Index into the (P, M) table |
| up | output | 1 | Detector request to raise oscillator frequency |
| down | output | 1 | Detector request to lower oscillator frequency |
| refStrobe | output | 1 | One-cycle pulse at each reference count wrap |
| fbStrobe | output | 1 | One-cycle pulse at each feedback count wrap |

## Verification
A count that is off by one in either divider shows up at the first wrap as a strobe one input period early or late. Such an error is visible within a single P or M interval. A limit reloaded at the wrong moment shows up only at the first wrap after a code change, as an interval of the wrong length. Because of this, the bench logs every interval and looks at the interval on each side of the change. A detector that fails to clear shows up one cycle after the second strobe, as both requests high together or as a request that lingers.

// File: rtl/ratio_pll_pkg.sv
package ratio_pll_pkg;

  localparam int CODE_W = 4;

  // Per-cycle edge events handed from control to datapath.
  typedef struct packed {
    logic refTick;
    logic fbTick;
  } tick_t;

  // Pre-divide value applied to the selected reference.
  function automatic int unsigned refDivOf(input logic [CODE_W-1:0] code);
    case (code)
      4'b0000: return 1000;
      4'b0001: return 1001;
      4'b0010: return 11000;
      4'b0011: return 11011;
      4'b0100: return 11000;
      4'b0101: return 4004;
      4'b0110: return 4004;
      4'b0111: return 1000;
      4'b1000: return 250;
      4'b1001: return 253;
      4'b1010: return 92;
      default: return 1;
    endcase
  endfunction

  // Feedback divide value applied to the oscillator clock.
  function automatic int unsigned fbDivOf(input logic [CODE_W-1:0] code);
    case (code)
      4'b0000: return 1000;
      4'b0001: return 1000;
      4'b0010: return 4004;
      4'b0011: return 4000;
      4'b0100: return 4000;
      4'b0101: return 4004;
      4'b0110: return 4000;
      4'b0111: return 1001;
      4'b1000: return 91;
      4'b1001: return 92;
      4'b1010: return 92;
      4'b1011: return 600;
      4'b1100: return 800;
      4'b1101: return 1728;
      4'b1110: return 1716;
      default: return 960;
    endcase
  endfunction

endpackage

// File: rtl/ratio_pll_divider.sv
module ratio_pll_divider
  import ratio_pll_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter bit USE_FB = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  output logic              wrapStb
);

  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] tableVal;
  logic             atLast;

  // Table value for the present code; only taken in at a wrap or in reset.
  always_comb begin
    if (USE_FB) tableVal = CNT_W'(fbDivOf(code));
    else        tableVal = CNT_W'(refDivOf(code));
  end

  assign atLast = (count == limit - STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      limit   <= tableVal;
      wrapStb <= 1'b0;
    end else begin
      wrapStb <= 1'b0;
      if (tick) begin
        if (atLast) begin
          count   <= '0;
          limit   <= tableVal;
          wrapStb <= 1'b1;
        end else begin
          count <= count + STEP;
        end
      end
    end
  end

endmodule

// File: rtl/ratio_pll_datapath.sv
module ratio_pll_datapath
  import ratio_pll_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  tick_t             ticks,
  input  logic [CODE_W-1:0] code,
  output logic [1:0]        wraps
);

  localparam int N_DIV = 2;

  logic [N_DIV-1:0] tickVec;
  assign tickVec = {ticks.fbTick, ticks.refTick};

  // Lane 0 divides the reference by P, lane 1 the feedback by M.
  for (genvar g = 0; g < N_DIV; g++) begin : g_div
    ratio_pll_divider #(
      .CNT_W (CNT_W),
      .USE_FB(g == 1)
    ) div_i (
      .clk    (clk),
      .rst    (rst),
      .tick   (tickVec[g]),
      .code   (code),
      .wrapStb(wraps[g])
    );
  end

endmodule

// File: rtl/ratio_pll_ctrl.sv
module ratio_pll_ctrl
  import ratio_pll_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       refClk0,
  input  logic       refClk1,
  input  logic       fbClk,
  input  logic       refSel,
  input  logic [1:0] wraps,
  output tick_t      ticks,
  output logic       up,
  output logic       down
);

  logic refLvl;
  logic refPrev;
  logic fbPrev;
  logic upSet;
  logic downSet;

  assign refLvl = refSel ? refClk1 : refClk0;

  // Previous samples track the inputs even in reset, so release
  // does not invent an edge.
  always_ff @(posedge clk) begin
    refPrev <= refLvl;
    fbPrev  <= fbClk;
  end

  always_comb begin
    ticks.refTick = refLvl & ~refPrev;
    ticks.fbTick  = fbClk & ~fbPrev;
  end

  // Phase-frequency detector: set by strobes, cleared when both are set.
  assign upSet   = up | wraps[0];
  assign downSet = down | wraps[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      up   <= 1'b0;
      down <= 1'b0;
    end else if (upSet && downSet) begin
      up   <= 1'b0;
      down <= 1'b0;
    end else begin
      up   <= upSet;
      down <= downSet;
    end
  end

endmodule

// File: rtl/ratio_pll_core.sv
module ratio_pll_core
  import ratio_pll_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              refClk0,
  input  logic              refClk1,
  input  logic              fbClk,
  input  logic              refSel,
  input  logic [CODE_W-1:0] ratioCode,
  output logic              up,
  output logic              down,
  output logic              refStrobe,
  output logic              fbStrobe
);

  tick_t      ticks;
  logic [1:0] wraps;

  ratio_pll_ctrl ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .refClk0(refClk0),
    .refClk1(refClk1),
    .fbClk  (fbClk),
    .refSel (refSel),
    .wraps  (wraps),
    .ticks  (ticks),
    .up     (up),
    .down   (down)
  );

  ratio_pll_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk  (clk),
    .rst  (rst),
    .ticks(ticks),
    .code (ratioCode),
    .wraps(wraps)
  );

  assign refStrobe = wraps[0];
  assign fbStrobe  = wraps[1];

endmodule

// File: rtl/ratio_pll_core_chk.sv
module ratio_pll_core_chk (
  input logic clk,
  input logic rst,
  input logic up,
  input logic down,
  input logic refStrobe,
  input logic fbStrobe
);

  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(up && down));

  // R9
  ref_single_chk: assert property (@(posedge clk) disable iff (rst)
    refStrobe |=> !refStrobe);

  // R9
  fb_single_chk: assert property (@(posedge clk) disable iff (rst)
    fbStrobe |=> !fbStrobe);

  // R7
  up_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (refStrobe && !down && !fbStrobe) |=> up);

  // R7
  down_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (fbStrobe && !up && !refStrobe) |=> down);

  // R7
  up_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (up && fbStrobe) |=> (!up && !down));

  // R7
  down_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (down && refStrobe) |=> (!up && !down));

  // R6
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!refStrobe && !fbStrobe && !up && !down));

endmodule

bind ratio_pll_core ratio_pll_core_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .up       (up),
  .down     (down),
  .refStrobe(refStrobe),
  .fbStrobe (fbStrobe)
);

// File: tb/ratio_pll_core_tb_top.sv
module ratio_pll_core_tb_top;

  localparam int CLK_PERIOD      = 10;
  localparam int WATCHDOG_CYCLES = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       refClk0 = 1'b0;
  logic       refClk1 = 1'b0;
  logic       fbClk = 1'b0;
  logic       refSel = 1'b0;
  logic [3:0] ratioCode = 4'b0000;
  logic       up, down, refStrobe, fbStrobe;

  int vectors = 0;
  int miscompares = 0;

  // Configuration written by the test sequence, applied at the next negedge.
  bit       cfgRst = 1'b1;
  bit       cfgSel = 1'b0;
  bit [3:0] cfgCode = 4'b0000;
  int       r0Half = 1, r1Half = 3, fbHalf = 1;
  int       r0Ph = 0, r1Ph = 0, fbPh = 0;

  // Behavioural reference model state.
  int mRefCnt = 0, mRefLim = 1000, mFbCnt = 0, mFbLim = 1000;
  bit mPrevRef = 0, mPrevFb = 0, mRefS = 0, mFbS = 0, mUp = 0, mDown = 0;
  bit stepped = 0;

  // Port observation logs.
  int cycle = 0;
  int refLog[$];
  int fbLog[$];
  int lastRefCyc = -1, lastFbCyc = -1;
  int refAtApply = 0, fbAtApply = 0;
  int overlapCount = 0, upRises = 0, doubleStrobes = 0;
  bit prevUp = 0, prevRefS = 0, prevFbS = 0;

  ratio_pll_core dut_i (
    .clk      (clk),
    .rst      (rst),
    .refClk0  (refClk0),
    .refClk1  (refClk1),
    .fbClk    (fbClk),
    .refSel   (refSel),
    .ratioCode(ratioCode),
    .up       (up),
    .down     (down),
    .refStrobe(refStrobe),
    .fbStrobe (fbStrobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int pOf(input bit [3:0] c);
    int t[16] = '{1000, 1001, 11000, 11011, 11000, 4004, 4004, 1000,
                  250, 253, 92, 1, 1, 1, 1, 1};
    return t[c];
  endfunction

  function automatic int mOf(input bit [3:0] c);
    int t[16] = '{1000, 1000, 4004, 4000, 4000, 4004, 4000, 1001,
                  91, 92, 92, 600, 800, 1728, 1716, 960};
    return t[c];
  endfunction

  task automatic checkEq(input string tag, input int actual, input int expected);
    vectors++;
    if (actual != expected) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic waitLogs(input int refN, input int fbN);
    while (refLog.size() < refN || fbLog.size() < fbN) tick();
  endtask

  // Compare, observe, drive and advance the model, once per cycle.
  always @(negedge clk) begin
    bit lvl, refEdge, fbEdge, nu, nd, nRefS, nFbS;
    cycle++;
    if (stepped) begin
      checkEq("R2 refStrobe per-cycle", int'(refStrobe), int'(mRefS));
      checkEq("R3 fbStrobe per-cycle", int'(fbStrobe), int'(mFbS));
      checkEq("R7 up per-cycle", int'(up), int'(mUp));
      checkEq("R7 down per-cycle", int'(down), int'(mDown));
    end
    if (up && down) overlapCount++;
    if (up && !prevUp) upRises++;
    if ((refStrobe && prevRefS) || (fbStrobe && prevFbS)) doubleStrobes++;
    prevUp = up; prevRefS = refStrobe; prevFbS = fbStrobe;
    if (rst) begin
      lastRefCyc = -1;
      lastFbCyc = -1;
    end
    if (refStrobe) begin
      if (lastRefCyc >= 0) refLog.push_back(cycle - lastRefCyc);
      lastRefCyc = cycle;
    end
    if (fbStrobe) begin
      if (lastFbCyc >= 0) fbLog.push_back(cycle - lastFbCyc);
      lastFbCyc = cycle;
    end
    if (cfgCode != ratioCode || cfgSel != refSel || cfgRst != rst) begin
      refAtApply = refLog.size();
      fbAtApply = fbLog.size();
    end

    r0Ph++; if (r0Ph >= r0Half) begin r0Ph = 0; refClk0 = ~refClk0; end
    r1Ph++; if (r1Ph >= r1Half) begin r1Ph = 0; refClk1 = ~refClk1; end
    fbPh++; if (fbPh >= fbHalf) begin fbPh = 0; fbClk = ~fbClk; end
    rst = cfgRst;
    refSel = cfgSel;
    ratioCode = cfgCode;

    lvl = cfgSel ? refClk1 : refClk0;
    if (cfgRst) begin
      mRefCnt = 0; mFbCnt = 0;
      mRefLim = pOf(cfgCode); mFbLim = mOf(cfgCode);
      mRefS = 0; mFbS = 0; mUp = 0; mDown = 0;
    end else begin
      nu = mUp | mRefS;
      nd = mDown | mFbS;
      if (nu && nd) begin nu = 0; nd = 0; end
      refEdge = lvl && !mPrevRef;
      fbEdge = fbClk && !mPrevFb;
      nRefS = 0; nFbS = 0;
      if (refEdge) begin
        if (mRefCnt + 1 == mRefLim) begin
          mRefCnt = 0; mRefLim = pOf(cfgCode); nRefS = 1;
        end else mRefCnt++;
      end
      if (fbEdge) begin
        if (mFbCnt + 1 == mFbLim) begin
          mFbCnt = 0; mFbLim = mOf(cfgCode); nFbS = 1;
        end else mFbCnt++;
      end
      mRefS = nRefS; mFbS = nFbS; mUp = nu; mDown = nd;
    end
    mPrevRef = lvl;
    mPrevFb = fbClk;
    stepped = 1;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    miscompares++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycle);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int k, kf;
    // R6: quiet outputs while held in reset
    cfgRst = 1;
    repeat (6) tick();
    checkEq("R6 reset refStrobe", int'(refStrobe), 0);
    checkEq("R6 reset fbStrobe", int'(fbStrobe), 0);
    checkEq("R6 reset up", int'(up), 0);
    checkEq("R6 reset down", int'(down), 0);

    // R2 R3 R4: code 0000 from release, full counts
    cfgCode = 4'b0000; cfgSel = 0; r0Half = 1; r1Half = 3; fbHalf = 1;
    cfgRst = 0;
    tick();
    k = refAtApply; kf = fbAtApply;
    waitLogs(k + 1, kf + 1);
    checkEq("R6 R2 first ref interval after release code 0000", refLog[k], 2000);
    checkEq("R6 R3 first fb interval after release code 0000", fbLog[kf], 2000);

    // R1 R4: select clock 1 (period 4), code 0001 gives P 1001
    cfgSel = 1; r1Half = 2; cfgCode = 4'b0001;
    tick();
    k = refAtApply; kf = fbAtApply;
    waitLogs(k + 2, kf + 2);
    checkEq("R1 R4 ref interval on refClk1 code 0001", refLog[k + 1], 4004);
    checkEq("R3 R4 fb interval code 0001", fbLog[kf + 1], 2000);

    // R1 R4: back to clock 0, code 1011 gives P 1 and M 600
    cfgSel = 0; cfgCode = 4'b1011;
    tick();
    k = refAtApply; kf = fbAtApply;
    waitLogs(k + 2, kf + 2);
    checkEq("R1 R4 ref interval P=1 code 1011", refLog[k + 1], 2);
    checkEq("R3 R4 fb interval code 1011", fbLog[kf + 1], 1200);

    // settle on code 0000 again
    cfgCode = 4'b0000;
    tick();
    k = refAtApply; kf = fbAtApply;
    waitLogs(k + 2, kf + 2);
    checkEq("R4 ref interval code 0000 again", refLog[k + 1], 2000);

    // R5: change mid-count, old count completes, then new values apply
    repeat (300) tick();
    cfgCode = 4'b0011;
    tick();
    k = refAtApply; kf = fbAtApply;
    waitLogs(k + 2, kf + 2);
    checkEq("R5 ref interval straddling change keeps old P", refLog[k], 2000);
    checkEq("R5 fb interval straddling change keeps old M", fbLog[kf], 2000);
    checkEq("R4 R5 ref interval code 0011", refLog[k + 1], 22022);
    checkEq("R4 R5 fb interval code 0011", fbLog[kf + 1], 8000);

    // R6: reset in mid-run silences outputs
    cfgRst = 1;
    repeat (4) tick();
    checkEq("R6 mid-run reset refStrobe", int'(refStrobe), 0);
    checkEq("R6 mid-run reset up", int'(up), 0);
    checkEq("R6 mid-run reset down", int'(down), 0);
    cfgRst = 0;
    repeat (4) tick();

    // R7 R8 R9 over the whole run
    checkEq("R8 cycles with up and down both high", overlapCount, 0);
    checkEq("R9 strobes lasting two cycles", doubleStrobes, 0);
    checkEq("R7 up pulses seen", int'(upRises > 0), 1);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule